// File: doc/BRIEF.md
# Glitch-Free Gated Clock Divider

This block distributes one of two incoming clocks to two output banks. A static select line picks the source. A gate-enable input is resynchronized to the chosen clock: a rising-edge flop captures it, then a latch that is open while the clock is low passes it on. The gate therefore only opens or closes while the clock is low, and no output pulse is ever cut short.

Bank A repeats the selected clock at full rate. Bank B toggles on every gated rising edge, so it runs at half rate. Each bank drives a parameterized number of identical true/complement pairs. An active-high master reset clears the synchronizer and the divider, and parks every output at its idle level.

Top module: `gated_clk_div`

## Requirements
- R1: With `selB` low the outputs are derived from `clkA`; with `selB` high they are derived from `clkB`.
- R2: When the enable has been low long enough to pass the synchronizer, every true output is 0 and every complement output is 1.
- R3: A change on `enReq` made while the selected clock is low is captured at the next rising edge and reaches the outputs only at the falling edge after it. The first output high phase affected is the second one after the change.
- R4: While `rstHi` is 1, every true output is 0 and every complement output is 1, whatever `enReq` and `selB` are. Reset also clears the divider.
- R5: Bank B toggles on every gated rising edge. Within each enabled window of n bank-A pulses, bank B shows exactly ceil(n/2) rising edges.
- R6: All pairs of a bank carry the same value, and each complement output is the bitwise inverse of its true output.
- R7: While enabled, bank A is non-inverting: high exactly while the selected clock is high.
- R8: After reset or after re-enable, the first transition of bank B is a rise, coincident with the first bank-A rise.
- R9: Every high and low pulse on either bank lasts at least half a period of the selected clock, across arbitrary enable toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | First clock source (selected when `selB` is 0) |
| clkB | input | 1 | Second clock source (selected when `selB` is 1) |
| selB | input | 1 | Static source select |
| enReq | input | 1 | Asynchronous gate enable request, active high |
| rstHi | input | 1 | Master reset, active high, asynchronous |
| qA | output | NUM_A | Bank A true outputs, divide-by-1 |
| qAN | output | NUM_A | Bank A complement outputs |
| qB | output | NUM_B | Bank B true outputs, divide-by-2 |
| qBN | output | NUM_B | Bank B complement outputs |

## Verification
The assertions assume three things about the inputs:
- `selB` only changes while `rstHi` is held.
- `enReq` only moves while the selected clock is low.
- `rstHi` edges never coincide with a clock edge.

Under these assumptions, a stable enable seen at two consecutive falling edges fully determines the gate in the next high phase. The bench keeps to them: it changes the select only under reset, drives the enable half a nanosecond after a falling edge of the selected source, and releases reset in a low phase. Its random phases toggle the enable on those falling edges for each source. Meanwhile, monitors record the minimum pulse width and count edges per enabled window.

// File: rtl/gated_clk_div_pkg.sv
package gated_clk_div_pkg;
  // Strobes from the enable synchronizer to the datapath.
  typedef struct packed {
    logic gateOpen;  // latched enable, changes only while the clock is low
    logic divHold;   // divider forced to zero on the next rising edge
  } gateCtl_t;
endpackage

// File: rtl/gated_clk_en_sync.sv
module gated_clk_en_sync
  import gated_clk_div_pkg::*;
(
  input  logic     srcClk,
  input  logic     rstHi,
  input  logic     enReq,
  output gateCtl_t ctl
);
  logic enCapt;
  logic enHeld;

  // Stage 1: capture on the rising edge of the selected clock.
  always_ff @(posedge srcClk or posedge rstHi) begin
    if (rstHi) enCapt <= 1'b0;
    else       enCapt <= enReq;
  end

  // Stage 2: latch open during the low phase, closed during the high phase.
  always_latch begin
    if (rstHi)        enHeld = 1'b0;
    else if (!srcClk) enHeld = enCapt;
  end

  always_comb begin
    ctl.gateOpen = enHeld;
    ctl.divHold  = ~enHeld;
  end
endmodule

// File: rtl/gated_clk_datapath.sv
module gated_clk_datapath
  import gated_clk_div_pkg::*;
#(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             selB,
  input  logic             rstHi,
  input  gateCtl_t         ctl,
  output logic             srcClk,
  output logic [NUM_A-1:0] qA,
  output logic [NUM_A-1:0] qAN,
  output logic [NUM_B-1:0] qB,
  output logic [NUM_B-1:0] qBN
);
  logic gatedClk;
  logic halfQ;

  assign srcClk   = selB ? clkB : clkA;
  assign gatedClk = srcClk & ctl.gateOpen;

  // Divide-by-2: advances only on rising edges where the gate is open,
  // so it matches rising edges of gatedClk; it starts at zero when closed.
  always_ff @(posedge srcClk or posedge rstHi) begin
    if (rstHi)            halfQ <= 1'b0;
    else if (ctl.divHold) halfQ <= 1'b0;
    else                  halfQ <= ~halfQ;
  end

  for (genvar i = 0; i < NUM_A; i++) begin : g_bankA
    assign qA[i]  = gatedClk;
    assign qAN[i] = ~gatedClk;
  end

  for (genvar j = 0; j < NUM_B; j++) begin : g_bankB
    assign qB[j]  = halfQ;
    assign qBN[j] = ~halfQ;
  end
endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
  import gated_clk_div_pkg::*;
#(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             selB,
  input  logic             enReq,
  input  logic             rstHi,
  output logic [NUM_A-1:0] qA,
  output logic [NUM_A-1:0] qAN,
  output logic [NUM_B-1:0] qB,
  output logic [NUM_B-1:0] qBN
);
  gateCtl_t ctl;
  logic     srcClk;

  gated_clk_en_sync u_sync (
    .srcClk (srcClk),
    .rstHi  (rstHi),
    .enReq  (enReq),
    .ctl    (ctl)
  );

  gated_clk_datapath #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_dp (
    .clkA   (clkA),
    .clkB   (clkB),
    .selB   (selB),
    .rstHi  (rstHi),
    .ctl    (ctl),
    .srcClk (srcClk),
    .qA     (qA),
    .qAN    (qAN),
    .qB     (qB),
    .qBN    (qBN)
  );
endmodule

// File: rtl/gated_clk_div_chk.sv
module gated_clk_div_chk #(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input logic             clkA,
  input logic             clkB,
  input logic             selB,
  input logic             enReq,
  input logic             rstHi,
  input logic [NUM_A-1:0] qA,
  input logic [NUM_A-1:0] qAN,
  input logic [NUM_B-1:0] qB,
  input logic [NUM_B-1:0] qBN
);
  logic chkClk;
  assign chkClk = selB ? clkB : clkA;

  // R4: reset parks all outputs
  p_reset_park_r4: assert property (@(negedge clkA)
    rstHi |-> (qA == '0 && qB == '0 && qAN == '1 && qBN == '1));

  // R6: complements invert their true outputs
  p_comp_inv_r6: assert property (@(negedge clkA) disable iff (rstHi)
    (qAN == ~qA) && (qBN == ~qB));

  // R6: pairs within a bank agree
  p_pairs_same_r6: assert property (@(negedge clkA) disable iff (rstHi)
    ($countones(qA) == 0 || $countones(qA) == NUM_A) &&
    ($countones(qB) == 0 || $countones(qB) == NUM_B));

  // R5: bank B never stays high across two rising edges
  p_half_rate_r5: assert property (@(posedge chkClk) disable iff (rstHi)
    qB[0] |=> !qB[0]);

  // R2: enable low at two falling edges closes the gate for the next high phase
  p_parked_r2: assert property (@(negedge chkClk) disable iff (rstHi)
    (!enReq && !$past(enReq)) |=> (qA == '0));

  // R7: enable high at two falling edges opens the gate for the next high phase
  p_follow_r7: assert property (@(negedge chkClk) disable iff (rstHi)
    (enReq && $past(enReq)) |=> (qA == '1));
endmodule

bind gated_clk_div gated_clk_div_chk #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_chk (
  .clkA  (clkA),
  .clkB  (clkB),
  .selB  (selB),
  .enReq (enReq),
  .rstHi (rstHi),
  .qA    (qA),
  .qAN   (qAN),
  .qB    (qB),
  .qBN   (qBN)
);

// File: tb/gated_clk_div_test.sv
`timescale 1ns/1ps
module gated_clk_div_test;
  localparam int NA = 2;
  localparam int NB = 2;

  logic clkA = 1'b0, clkB = 1'b0;
  logic selB = 1'b0, enReq = 1'b1, rstHi = 1'b1;
  logic [NA-1:0] qA, qAN;
  logic [NB-1:0] qB, qBN;
  logic srcTb;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clkA = ~clkA;  // 200 MHz
  always #3.5 clkB = ~clkB;
  assign srcTb = selB ? clkB : clkA;

  gated_clk_div #(.NUM_A(NA), .NUM_B(NB)) uut (
    .clkA(clkA), .clkB(clkB), .selB(selB), .enReq(enReq), .rstHi(rstHi),
    .qA(qA), .qAN(qAN), .qB(qB), .qBN(qBN));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit parked();
    return qA == '0 && qB == '0 && qAN == '1 && qBN == '1;
  endfunction

  function automatic bit consistent();
    return qAN == ~qA && qBN == ~qB &&
           (qA == '0 || qA == '1) && (qB == '0 || qB == '1);
  endfunction

  function automatic real halfPer();
    return selB ? 3.5 : 2.5;
  endfunction

  task automatic highPhase();  // sample 1 ns into the next high phase
    @(posedge srcTb); #1;
  endtask

  task automatic afterFall();  // drive 0.5 ns after a falling edge
    @(negedge srcTb); #0.5;
  endtask

  // Monitors for R9 pulse widths and R5 window counts
  bit   monOn = 0;
  real  lastA = 0.0, lastB = 0.0, minA = 1.0e9, minB = 1.0e9;
  int   nA = 0, expB = 0, gotB = 0;

  always @(qA[0]) begin
    if (monOn && !rstHi && ($realtime - lastA) < minA) minA = $realtime - lastA;
    lastA = $realtime;
  end
  always @(qB[0]) begin
    if (monOn && !rstHi && ($realtime - lastB) < minB) minB = $realtime - lastB;
    lastB = $realtime;
  end
  always @(posedge qB[0]) if (monOn) gotB++;
  always @(posedge srcTb) begin
    #1;
    if (monOn) begin
      if (qA[0]) nA++;
      else if (nA > 0) begin expB += (nA + 1) / 2; nA = 0; end
    end
  end

  task automatic resetTo(input logic s);
    #0.3 rstHi = 1'b1;
    #1;
    check(parked(), "R4 reset parks outputs", int'(qA[0]), 0);
    selB = s;
    enReq = 1'b1;
    #20;
    check(parked(), "R4 reset ignores enable/select", int'(qB[0]), 0);
    afterFall();
    rstHi = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(parked(), "R4 reset state", int'(qA[0]), 0);
    resetTo(1'b0);

    // R3/R8: first rise not before the second high phase after release
    highPhase();
    check(qA == '0, "R3 enable delay after reset", int'(qA[0]), 0);
    highPhase();
    check(qA == '1, "R7 bank A high in high phase", int'(qA[0]), 1);
    check(qB == '1, "R8 bank B first transition high", int'(qB[0]), 1);
    check(consistent(), "R6 pairs and complements", int'(qAN[0]), 0);
    #(halfPer());
    check(qA == '0, "R7 bank A low in low phase", int'(qA[0]), 0);
    highPhase();
    check(qB == '0, "R5 bank B toggles low", int'(qB[0]), 0);
    highPhase();
    check(qB == '1, "R5 bank B toggles high", int'(qB[0]), 1);

    // R3/R2: disable takes effect at the second high phase
    afterFall(); enReq = 1'b0;
    highPhase();
    check(qA == '1, "R3 disable delayed one phase", int'(qA[0]), 1);
    highPhase();
    check(parked(), "R2 disabled outputs parked", int'(qA[0]), 0);
    repeat (3) highPhase();
    check(parked(), "R2 stays parked", int'(qB[0]), 0);

    // R3/R8: re-enable
    afterFall(); enReq = 1'b1;
    highPhase();
    check(qA == '0, "R3 enable delayed one phase", int'(qA[0]), 0);
    highPhase();
    check(qA == '1 && qB == '1, "R8 re-enable bank B rises first", int'(qB[0]), 1);

    // R1: source selection by counting bank A pulses over 70 ns
    for (int s = 0; s < 2; s++) begin
      int cnt;
      resetTo(logic'(s));
      repeat (3) highPhase();
      cnt = 0;
      fork
        begin : cntLoop
          forever begin @(posedge qA[0]); cnt++; end
        end
        #70;
      join_any
      disable fork;
      check(cnt == (s ? 10 : 14), "R1 source selection rate", cnt, s ? 10 : 14);
    end

    // Random enable toggling per source: R9 widths, R5 window counts
    for (int s = 0; s < 2; s++) begin
      resetTo(logic'(s));
      minA = 1.0e9; minB = 1.0e9; nA = 0; expB = 0; gotB = 0;
      monOn = 1;
      for (int k = 0; k < 600; k++) begin
        afterFall();
        if ($urandom % 4 == 0) enReq = ~enReq;
        if (!consistent()) check(0, "R6 consistency in random run", int'(qAN[0]), int'(~qA[0]));
      end
      afterFall(); enReq = 1'b0;
      repeat (4) highPhase();
      monOn = 0;
      check(minA >= halfPer() - 0.01, "R9 bank A min pulse width",
            int'(minA * 1000), int'(halfPer() * 1000));
      check(minB >= halfPer() - 0.01, "R9 bank B min pulse width",
            int'(minB * 1000), int'(halfPer() * 1000));
      check(gotB == expB && expB > 0, "R5 bank B edges per window", gotB, expB);
    end

    // R4: reset mid-run while enabled
    resetTo(1'b1);
    repeat (4) highPhase();
    #0.2 rstHi = 1'b1;
    #0.5;
    check(parked(), "R4 reset mid-run parks outputs", int'(qA[0]), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule